// File: doc/BRIEF.md
# Tiled Partial-Sum Accumulator

This block forms one element of a matrix product when the inner dimension N is larger than the four multiplier lanes of a column. Each cycle it receives four products and adds them together in one combinational step. A countdown preset to N/4 tracks how many groups of four remain. While the count is nonzero, the stored partial sum is fed back and added to the new group. When the count reaches zero, the feedback path closes and the output path opens for one cycle. A start accepted in that same cycle makes the next element's first group load into the register directly, with no feedback.

A caller pulses the start strobe with the order N. It then presents the N/4 groups of products on the N/4 cycles that follow the start edge, and collects the result when the valid strobe pulses. An order that is not a nonzero multiple of four, or that exceeds the supported maximum, raises an error flag. In that case no result is produced.

Top module: `tiled_psum_acc`

## Requirements
- R1: While reset is held and right after it, `valid_o`, `result_o` and `err_o` are all zero.
- R2: A start with a legal order N (nonzero, a multiple of 4, at most MAX_N) presets the countdown to N/4. The block consumes exactly the N/4 product groups presented on the N/4 cycles after the start edge.
- R3: The first group of every element loads into the register without feedback, so nothing from an earlier element reaches the new result.
- R4: The four lanes of `prod_i` (lane k at bits [32k+31:32k], unsigned) are summed in one step. While the count is nonzero, the stored partial sum is added to that group sum.
- R5: `valid_o` is a one-cycle pulse in the cycle after the last group, that is N/4+1 cycles after the start edge. In that cycle `result_o` equals the sum of all N products.
- R6: `result_o` reads zero in every cycle where `valid_o` is low.
- R7: A start with an illegal order sets `err_o` from the next cycle and produces no result. The next legal start clears `err_o`.
- R8: The accumulator is 32 + log2(MAX_N) bits wide, so N products of all ones sum without overflow.
- R9: A start that arrives while an element is still being accumulated, outside its output cycle, is ignored.
- R10: A start in the output cycle is accepted, so elements can follow back to back with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe for a new result element |
| order_i | input | 7 | Inner dimension N, sampled with start_i |
| prod_i | input | 128 | Four unsigned 32-bit products, lane k at [32k+31:32k] |
| result_o | output | 38 | Finished element, zero when valid_o is low |
| valid_o | output | 1 | One-cycle pulse marking result_o |
| err_o | output | 1 | Last accepted order was illegal |

## Verification
After a start edge for order N, the groups are due on the next N/4 cycles and the result N/4+1 cycles after that edge. The error flag is due one cycle after the start edge. The bench drives every input on the falling edge. It checks outputs at the falling edge of exactly the cycle each result is due, and it also checks that valid stays low on every group cycle and goes low again one cycle after the result. Back-to-back and ignored-start cases place the second strobe on a known cycle, so the due cycle of each result stays fixed.

// File: rtl/tiled_psum_pkg.sv
package tiled_psum_pkg;
  // legality of an inner dimension for a given lane count and capacity
  function automatic logic order_legal(input int unsigned n, input int unsigned lanes,
                                       input int unsigned max_n);
    return (n != 0) && ((n % lanes) == 0) && (n <= max_n);
  endfunction

  // number of lane groups for a legal order
  function automatic int unsigned group_count(input int unsigned n, input int unsigned lanes);
    return n / lanes;
  endfunction
endpackage

// File: rtl/lane_summer.sv
module lane_summer #(
  parameter int LANES  = 4,
  parameter int DATA_W = 32,
  parameter int SUM_W  = 38
) (
  input  logic [LANES*DATA_W-1:0] prods,
  output logic [SUM_W-1:0]        sum
);
  // one combinational block adds every lane at once
  always_comb begin
    sum = '0;
    for (int i = 0; i < LANES; i++) begin
      sum = sum + SUM_W'(prods[i*DATA_W +: DATA_W]);
    end
  end
endmodule

// File: rtl/tile_sequencer.sv
module tile_sequencer
  import tiled_psum_pkg::*;
#(
  parameter int LANES = 4,
  parameter int MAX_N = 64,
  parameter int NW    = 7,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [NW-1:0] order_i,
  output logic          load_en,
  output logic          fb_en,
  output logic          out_en,
  output logic          err_o
);
  logic          busy;
  logic          first;
  logic [CW-1:0] cnt;
  logic          accept;
  logic          legal;

  assign legal   = order_legal(32'(order_i), LANES, MAX_N);
  assign out_en  = busy && (cnt == '0);
  assign load_en = busy && first;
  assign fb_en   = busy && !first && (cnt != '0);
  assign accept  = start_i && (!busy || out_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      first <= 1'b0;
      cnt   <= '0;
      err_o <= 1'b0;
    end else if (accept) begin
      err_o <= !legal;
      busy  <= legal;
      first <= legal;
      cnt   <= legal ? CW'(group_count(32'(order_i), LANES)) : '0;
    end else if (busy) begin
      first <= 1'b0;
      if (cnt != '0) cnt <= cnt - 1'b1;
      else           busy <= 1'b0;
    end
  end

  // R4: countdown steps by one per cycle while groups remain
  a_r4_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
  // R3: a start taken in the output cycle leads to a fresh load, no feedback
  a_r3_fresh_after_out: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && start_i && legal) |=> (load_en && !fb_en));
  // R7: an illegal start flags an error and starts nothing
  a_r7_err_on_bad: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy && !legal) |=> (err_o && !busy));
  // R9: a start mid-element does not disturb the running element
  a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !out_en) |=> busy);
endmodule

// File: rtl/tiled_psum_acc.sv
module tiled_psum_acc #(
  parameter int LANES  = 4,
  parameter int DATA_W = 32,
  parameter int MAX_N  = 64,
  localparam int NW    = $clog2(MAX_N) + 1,
  localparam int ACC_W = DATA_W + $clog2(MAX_N),
  localparam int CW    = $clog2(MAX_N / LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [NW-1:0]           order_i,
  input  logic [LANES*DATA_W-1:0] prod_i,
  output logic [ACC_W-1:0]        result_o,
  output logic                    valid_o,
  output logic                    err_o
);
  logic             load_en;
  logic             fb_en;
  logic             out_en;
  logic [ACC_W-1:0] group_sum;
  logic [ACC_W-1:0] acc_q;

  lane_summer #(.LANES(LANES), .DATA_W(DATA_W), .SUM_W(ACC_W)) summer_i (
    .prods(prod_i),
    .sum  (group_sum)
  );

  tile_sequencer #(.LANES(LANES), .MAX_N(MAX_N), .NW(NW), .CW(CW)) seq_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .order_i(order_i),
    .load_en(load_en),
    .fb_en  (fb_en),
    .out_en (out_en),
    .err_o  (err_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       acc_q <= '0;
    else if (load_en) acc_q <= group_sum;
    else if (fb_en)   acc_q <= acc_q + group_sum;
  end

  assign valid_o  = out_en;
  assign result_o = out_en ? acc_q : '0;

  // R8: feedback never wraps the accumulator
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fb_en |=> (acc_q >= $past(acc_q)));
  // R5: valid is a single-cycle pulse
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  // R6: output path closed outside the output cycle
  a_r6_quiet_result: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (result_o == '0));
endmodule

// File: tb/tiled_psum_acc_tb.sv
`timescale 1ns/1ps
module tiled_psum_acc_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [6:0]   order_i = '0;
  logic [127:0] prod_i = '0;
  logic [37:0]  result_o;
  logic         valid_o;
  logic         err_o;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tiled_psum_acc dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .order_i(order_i),
    .prod_i(prod_i), .result_o(result_o), .valid_o(valid_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pval(input int kind, input int grp, input int lane);
    if (kind == 0) return 32'hFFFF_FFFF;
    return 32'((grp * 4 + lane + 1) * 32'h9E37_79B1) ^ 32'(kind * 32'h0101_0101);
  endfunction

  // one element: optional start, groups, output cycle, optional chained start
  task automatic run_elem(input int n, input int kind, input bit skip_start,
                          input int next_n, input bit mid_start, input string req);
    longint expv = 0;
    int t = n / 4;
    if (!skip_start) begin
      @(negedge clk); start_i = 1'b1; order_i = 7'(n); prod_i = '0;
    end
    for (int g = 0; g < t; g++) begin
      @(negedge clk);
      start_i = 1'b0;
      if (mid_start && g == 1) begin start_i = 1'b1; order_i = 7'd4; end
      for (int l = 0; l < 4; l++) begin
        prod_i[l*32 +: 32] = pval(kind, g, l);
        expv += longint'(pval(kind, g, l));
      end
      chk(valid_o == 1'b0, {req, " R5 no early valid"}, longint'(valid_o), 0);
      chk(err_o == 1'b0, {req, " R7 err clear on legal"}, longint'(err_o), 0);
    end
    @(negedge clk);
    start_i = 1'b0; prod_i = '0;
    if (next_n != 0) begin start_i = 1'b1; order_i = 7'(next_n); end
    chk(valid_o == 1'b1, {req, " R5 valid due"}, longint'(valid_o), 1);
    chk(longint'(result_o) == expv, {req, " R4 result"}, longint'(result_o), expv);
    if (next_n == 0) begin
      @(negedge clk);
      chk(valid_o == 1'b0, {req, " R5 single pulse"}, longint'(valid_o), 0);
      chk(result_o == '0, {req, " R6 result zero"}, longint'(result_o), 0);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(valid_o == 1'b0 && result_o == '0 && err_o == 1'b0, "R1 reset outputs",
        longint'({valid_o, err_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(valid_o == 1'b0 && result_o == '0 && err_o == 1'b0, "R1 after reset",
        longint'(result_o), 0);
  endtask

  task automatic t_bad_order(input int n);
    @(negedge clk); start_i = 1'b1; order_i = 7'(n);
    @(negedge clk); start_i = 1'b0;
    chk(err_o == 1'b1, "R7 err set", longint'(err_o), 1);
    chk(valid_o == 1'b0, "R7 no result", longint'(valid_o), 0);
    repeat (2) begin
      @(negedge clk);
      chk(valid_o == 1'b0 && result_o == '0, "R7 stays idle", longint'(result_o), 0);
    end
    chk(err_o == 1'b1, "R7 err held", longint'(err_o), 1);
  endtask

  initial begin
    t_reset();
    run_elem(4, 1, 1'b0, 0, 1'b0, "R2 N=4");
    run_elem(8, 2, 1'b0, 0, 1'b0, "R2 N=8");
    run_elem(12, 3, 1'b0, 0, 1'b0, "R2 N=12");
    run_elem(64, 0, 1'b0, 0, 1'b0, "R8 N=64 all ones");
    t_bad_order(6);
    run_elem(8, 4, 1'b0, 0, 1'b0, "R7 clear");
    t_bad_order(0);
    t_bad_order(68);
    run_elem(8, 5, 1'b0, 0, 1'b1, "R9 mid start ignored");
    run_elem(12, 6, 1'b0, 8, 1'b0, "R10 chain first");
    run_elem(8, 7, 1'b1, 4, 1'b0, "R3 chain fresh");
    run_elem(4, 8, 1'b1, 0, 1'b0, "R3 chain last");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule